// File: doc/BRIEF.md
# Serial Panel Register Write Sequencer

This block writes 16-bit configuration registers inside a display panel controller over a one-way serial link. Each register write goes out as two framed transfers. The first names the target register. The second carries the value. Chip select returns high between the two transfers. A host loads a command code together with either a register number and value, or an output-mode request, and then pulses `start`. The block raises `busy` and shifts out every frame of the command. When the last frame is finished, it pulses `done`.

Three of the four command codes are fixed power sequences, built from single register writes:

- **Power-up** takes the panel out of shutdown and then programs the output-mode word.
- **Shutdown** puts the panel into its low-power state.
- **Resume** re-applies the stored output-mode word and then leaves shutdown.

The output-mode word combines a fixed default with four caller-selected orientation and colour-order bits. It is captured at power-up and kept for later resumes.

Top module: `panel_cfg_writer`

## Requirements
- R1: The register-select frame is 24 bits, sent MSB first: byte 0x74, then 0x00, then the 8-bit register number.
- R2: The value frame is 24 bits, sent MSB first: byte 0x76, then the value's high byte, then its low byte.
- R3: Every register write sends its select frame and then its value frame as two separate chip-select-low transfers. Chip select stays high for at least 2*HALF_DIV clock cycles (one SCLK period) between any two frames.
- R4: The serial timing follows SPI mode 3. SCLK is high whenever chip select is high. MOSI changes only while SCLK is low. Each SCLK phase lasts exactly HALF_DIV clock cycles, and each transfer has exactly 24 rising edges.
- R5: cmdSel=1 (power-up) writes 0x0000 to register 0x11 and then the output-mode word to register 0x01.
- R6: cmdSel=2 (shutdown) writes 0x0001 to register 0x11 and nothing else.
- R7: cmdSel=3 (resume) writes the stored output-mode word to register 0x01 and then 0x0000 to register 0x11.
- R8: The output-mode word is (0x2AEF AND NOT 0x6A00) OR (modeIn AND 0x6A00). Only modeIn bits 14, 13, 11 and 9 have any effect. The word is stored only by a power-up command, and it reads 0x00EF until the first power-up.
- R9: busy is high from the cycle after an accepted start until the last frame ends. done pulses for exactly one cycle as busy falls. A start seen while busy is ignored and does not change the stored output-mode word.
- R10: After reset, csN=1, sclk=1, busy=0 and done=0.
- R11: cmdSel=0 writes regVal to register regIdx as a single write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the selected command (ignored while busy) |
| cmdSel | input | 2 | 0 single write, 1 power-up, 2 shutdown, 3 resume |
| regIdx | input | 8 | Register number for a single write |
| regVal | input | 16 | Value for a single write |
| modeIn | input | 16 | Requested orientation/colour-order bits (masked) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse at the end of a command |
| spiSclk | output | 1 | Serial clock, idles high |
| spiMosi | output | 1 | Serial data out |
| spiCsN | output | 1 | Active-low chip select |

## Verification
The checker watches the link-level rules on every cycle:

- SCLK stays high while chip select is deasserted.
- MOSI holds steady while SCLK is high.
- Chip select is high whenever the block is idle.
- Chip select is high for the minimum gap before each new frame.
- done is a single-cycle pulse that coincides with busy falling.

Other behaviour can only be shown by the bench scenarios. These include the frame contents and their order within each sequence, and the masking of the output-mode request. They also include the persistence of the stored word across a resume issued before any power-up, and the rejection of a start issued mid-sequence. For these, the bench decodes the serial stream and compares the frames with lists it builds itself.

// File: rtl/panel_cfg_pkg.sv
package panel_cfg_pkg;
  localparam int FRAME_BITS = 24;

  typedef enum logic [1:0] {
    CMD_WRITE    = 2'd0,
    CMD_POWER_UP = 2'd1,
    CMD_SHUTDOWN = 2'd2,
    CMD_RESUME   = 2'd3
  } cmd_e;

  // control -> datapath strobes
  typedef struct packed {
    logic                  load;
    logic [FRAME_BITS-1:0] frame;
  } dpStrobe_t;

  localparam logic [7:0] PFX_INDEX   = 8'h74;
  localparam logic [7:0] PFX_DATA    = 8'h76;
  localparam logic [7:0] REG_SHUT    = 8'h11;
  localparam logic [7:0] REG_OUTMODE = 8'h01;
endpackage

// File: rtl/panel_cfg_dp.sv
module panel_cfg_dp
  import panel_cfg_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  output logic      frameDone,
  output logic      sclk,
  output logic      mosi,
  output logic      csN
);
  // half-period slots: 0..2*FRAME_BITS-1 carry bits, then CS release and gap
  localparam int HALF_BITS = 2 * FRAME_BITS;
  localparam int HALF_LAST = HALF_BITS + 2;
  localparam int HALF_W    = $clog2(HALF_LAST + 1);
  localparam int DIV_W     = $clog2(HALF_DIV + 1);
  localparam logic [HALF_W-1:0] SLOT_RELEASE = HALF_W'(HALF_BITS);
  localparam logic [HALF_W-1:0] SLOT_END     = HALF_W'(HALF_LAST);
  localparam logic [DIV_W-1:0]  DIV_TOP      = DIV_W'(HALF_DIV - 1);

  logic                  active;
  logic [DIV_W-1:0]      divCnt;
  logic [HALF_W-1:0]     halfCnt;
  logic [FRAME_BITS-1:0] shReg;
  logic                  tick;

  assign tick = active && (divCnt == DIV_TOP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      divCnt    <= '0;
      halfCnt   <= '0;
      shReg     <= '0;
      sclk      <= 1'b1;
      mosi      <= 1'b0;
      csN       <= 1'b1;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (strobe.load) begin
        active  <= 1'b1;
        divCnt  <= '0;
        halfCnt <= '0;
        shReg   <= strobe.frame;
        csN     <= 1'b0;
        sclk    <= 1'b1;
      end else if (active) begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) begin
          halfCnt <= halfCnt + 1'b1;
          if (halfCnt < SLOT_RELEASE) begin
            if (!halfCnt[0]) begin
              // falling edge: present next bit (mode 3, R4)
              sclk  <= 1'b0;
              mosi  <= shReg[FRAME_BITS-1];
              shReg <= {shReg[FRAME_BITS-2:0], 1'b0};
            end else begin
              sclk <= 1'b1;
            end
          end else if (halfCnt == SLOT_RELEASE) begin
            csN <= 1'b1;
          end else if (halfCnt == SLOT_END) begin
            // two half periods of CS high have elapsed (R3)
            active    <= 1'b0;
            frameDone <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/panel_cfg_ctrl.sv
module panel_cfg_ctrl
  import panel_cfg_pkg::*;
#(
  parameter logic [15:0] MODE_DEFAULT = 16'h2AEF,
  parameter logic [15:0] MODE_MASK    = 16'h6A00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [1:0]  cmd,
  input  logic [7:0]  regIdx,
  input  logic [15:0] regVal,
  input  logic [15:0] modeIn,
  input  logic        frameDone,
  output dpStrobe_t   strobe,
  output logic        busy,
  output logic        done
);
  localparam logic [15:0] MODE_BASE = MODE_DEFAULT & ~MODE_MASK;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SEND} state_e;

  state_e      state;
  cmd_e        curCmd;
  logic [7:0]  regL;
  logic [15:0] valL;
  logic [15:0] storedMode;
  logic        stepIdx;
  logic        phase;     // 0 select frame, 1 value frame
  logic [7:0]  tReg;
  logic [15:0] tVal;
  logic        lastStep;

  // register write list per command (R5, R6, R7, R11)
  always_comb begin
    tReg     = REG_SHUT;
    tVal     = 16'h0000;
    lastStep = 1'b1;
    unique case (curCmd)
      CMD_WRITE: begin
        tReg = regL;
        tVal = valL;
      end
      CMD_POWER_UP: begin
        lastStep = stepIdx;
        if (stepIdx) begin
          tReg = REG_OUTMODE;
          tVal = storedMode;
        end
      end
      CMD_SHUTDOWN: tVal = 16'h0001;
      CMD_RESUME: begin
        lastStep = stepIdx;
        if (!stepIdx) begin
          tReg = REG_OUTMODE;
          tVal = storedMode;
        end
      end
    endcase
  end

  assign strobe.load  = (state == S_LOAD);
  assign strobe.frame = phase ? {PFX_DATA, tVal} : {PFX_INDEX, 8'h00, tReg};
  assign busy         = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      curCmd     <= CMD_WRITE;
      regL       <= '0;
      valL       <= '0;
      storedMode <= MODE_BASE;
      stepIdx    <= 1'b0;
      phase      <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          curCmd  <= cmd_e'(cmd);
          regL    <= regIdx;
          valL    <= regVal;
          stepIdx <= 1'b0;
          phase   <= 1'b0;
          if (cmd_e'(cmd) == CMD_POWER_UP)
            storedMode <= MODE_BASE | (modeIn & MODE_MASK);  // R8
          state <= S_LOAD;
        end
        S_LOAD: state <= S_SEND;
        S_SEND: if (frameDone) begin
          if (!phase) begin
            phase <= 1'b1;
            state <= S_LOAD;
          end else if (!lastStep) begin
            stepIdx <= 1'b1;
            phase   <= 1'b0;
            state   <= S_LOAD;
          end else begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/panel_cfg_writer.sv
module panel_cfg_writer
  import panel_cfg_pkg::*;
#(
  parameter int          HALF_DIV     = 4,
  parameter logic [15:0] MODE_DEFAULT = 16'h2AEF,
  parameter logic [15:0] MODE_MASK    = 16'h6A00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [1:0]  cmdSel,
  input  logic [7:0]  regIdx,
  input  logic [15:0] regVal,
  input  logic [15:0] modeIn,
  output logic        busy,
  output logic        done,
  output logic        spiSclk,
  output logic        spiMosi,
  output logic        spiCsN
);
  dpStrobe_t strobe;
  logic      frameDone;

  panel_cfg_ctrl #(
    .MODE_DEFAULT(MODE_DEFAULT),
    .MODE_MASK   (MODE_MASK)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cmd      (cmdSel),
    .regIdx   (regIdx),
    .regVal   (regVal),
    .modeIn   (modeIn),
    .frameDone(frameDone),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  panel_cfg_dp #(
    .HALF_DIV(HALF_DIV)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .frameDone(frameDone),
    .sclk     (spiSclk),
    .mosi     (spiMosi),
    .csN      (spiCsN)
  );
endmodule

// File: rtl/panel_cfg_chk.sv
module panel_cfg_chk #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic spiSclk,
  input logic spiMosi,
  input logic spiCsN
);
  localparam int GAP_MIN = 2 * HALF_DIV;
  localparam int GAP_W   = $clog2(GAP_MIN + 1);
  localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(GAP_MIN);

  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN) gapCnt <= GAP_SAT;
    else if (!spiCsN) gapCnt <= '0;
    else if (gapCnt < GAP_SAT) gapCnt <= gapCnt + 1'b1;
  end

  a_r4_sclk_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> spiSclk);

  a_r4_mosi_hold: assert property (@(posedge clk) disable iff (!rstN)
    spiSclk |-> $stable(spiMosi));

  a_r9_cs_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> spiCsN);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_done_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  a_r3_cs_gap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |-> (gapCnt >= GAP_SAT));
endmodule

bind panel_cfg_writer panel_cfg_chk #(.HALF_DIV(HALF_DIV)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .busy   (busy),
  .done   (done),
  .spiSclk(spiSclk),
  .spiMosi(spiMosi),
  .spiCsN (spiCsN)
);

// File: tb/panel_cfg_writer_tb_top.sv
`timescale 1ns/1ps
module panel_cfg_writer_tb_top;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cmdSel = 2'd0;
  logic [7:0]  regIdx = 8'h00;
  logic [15:0] regVal = 16'h0000;
  logic [15:0] modeIn = 16'h0000;
  logic        busy, done, spiSclk, spiMosi, spiCsN;

  int nTests = 0;
  int nFail  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  panel_cfg_writer #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cmdSel(cmdSel),
    .regIdx(regIdx), .regVal(regVal), .modeIn(modeIn),
    .busy(busy), .done(done), .spiSclk(spiSclk), .spiMosi(spiMosi),
    .spiCsN(spiCsN)
  );

  // serial monitor, sampled at the falling clock edge
  logic [23:0] frames [0:7];
  int          nFrames = 0;
  logic [23:0] rxShift = '0;
  int          rxBits = 0;
  int          timingErr = 0;
  int          sinceEdge = 0;
  int          csHigh = 0;
  bit          edgeSeen = 0;
  logic        prevSclk = 1'b1, prevCs = 1'b1, prevMosi = 1'b0;

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      sinceEdge++;
      if (spiCsN && !spiSclk) timingErr++;                       // R4
      if (spiSclk && prevSclk && spiMosi !== prevMosi) timingErr++; // R4
      if (!spiCsN && prevCs) begin
        if (nFrames > 0 && csHigh < 2 * HALF) timingErr++;       // R3
        rxBits = 0;
        edgeSeen = 0;
      end
      if (spiSclk !== prevSclk && !spiCsN) begin
        if (edgeSeen && sinceEdge != HALF) timingErr++;          // R4
        edgeSeen = 1;
        sinceEdge = 0;
        if (spiSclk) begin
          rxShift = {rxShift[22:0], spiMosi};
          rxBits++;
        end
      end
      if (spiCsN && !prevCs) begin
        if (rxBits != 24) timingErr++;
        if (nFrames < 8) frames[nFrames] = rxShift;
        nFrames++;
      end
      csHigh = spiCsN ? csHigh + 1 : 0;
      prevSclk = spiSclk;
      prevCs   = spiCsN;
      prevMosi = spiMosi;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  logic [15:0] tbStored = 16'h00EF;

  function automatic logic [23:0] selFrame(input logic [7:0] r);
    return {8'h74, 8'h00, r};
  endfunction
  function automatic logic [23:0] valFrame(input logic [15:0] v);
    return {8'h76, v};
  endfunction

  task automatic runSeq(input logic [1:0] c, input logic [7:0] r,
                        input logic [15:0] v, input logic [15:0] m,
                        input bit poke, input string tag);
    logic [23:0] expF [0:3];
    int nExp;
    int w;
    case (c)
      2'd0: begin expF[0] = selFrame(r); expF[1] = valFrame(v); nExp = 2; end
      2'd1: begin
        tbStored = 16'h00EF | (m & 16'h6A00);
        expF[0] = selFrame(8'h11); expF[1] = valFrame(16'h0000);
        expF[2] = selFrame(8'h01); expF[3] = valFrame(tbStored); nExp = 4;
      end
      2'd2: begin expF[0] = selFrame(8'h11); expF[1] = valFrame(16'h0001); nExp = 2; end
      default: begin
        expF[0] = selFrame(8'h01); expF[1] = valFrame(tbStored);
        expF[2] = selFrame(8'h11); expF[3] = valFrame(16'h0000); nExp = 4;
      end
    endcase
    nFrames = 0;
    timingErr = 0;
    @(negedge clk);
    start = 1'b1; cmdSel = c; regIdx = r; regVal = v; modeIn = m;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9", {tag, " busy after start"}, 32'(busy), 32'd1);
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1'b1; cmdSel = 2'd1; regIdx = 8'h5A; regVal = 16'hFFFF; modeIn = 16'hFFFF;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (done !== 1'b1 && w < 5000) begin
      @(negedge clk);
      w++;
    end
    chk(w < 5000, "R9", {tag, " done seen"}, 32'(w), 32'd0);
    chk(busy === 1'b0, "R9", {tag, " busy low with done"}, 32'(busy), 32'd0);
    @(negedge clk);
    chk(done === 1'b0, "R9", {tag, " done one cycle"}, 32'(done), 32'd0);
    repeat (3) @(negedge clk);
    chk(nFrames == nExp, "R3", {tag, " frame count"}, 32'(nFrames), 32'(nExp));
    for (int i = 0; i < nExp && i < nFrames; i++)
      chk(frames[i] === expF[i], (i % 2 == 0) ? "R1" : "R2",
          $sformatf("%s frame %0d", tag, i), 32'(frames[i]), 32'(expF[i]));
    chk(timingErr == 0, "R4", {tag, " link timing"}, 32'(timingErr), 32'd0);
  endtask

  initial begin
    logic [7:0]  regs [0:5];
    logic [15:0] vals [0:3];
    regs = '{8'h00, 8'h01, 8'h11, 8'h80, 8'hFF, 8'hA5};
    vals = '{16'h0000, 16'hFFFF, 16'h8001, 16'h1234};
    repeat (5) @(negedge clk);
    // R10: reset state
    chk(spiCsN === 1'b1, "R10", "csN in reset", 32'(spiCsN), 32'd1);
    chk(spiSclk === 1'b1, "R10", "sclk in reset", 32'(spiSclk), 32'd1);
    chk(busy === 1'b0, "R10", "busy in reset", 32'(busy), 32'd0);
    chk(done === 1'b0, "R10", "done in reset", 32'(done), 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R8/R7: resume before any power-up uses the reset word
    runSeq(2'd3, 8'h00, 16'h0000, 16'h0000, 0, "R7 resume default");

    // R11: single writes over register/value patterns
    foreach (regs[i])
      foreach (vals[j])
        runSeq(2'd0, regs[i], vals[j], 16'hFFFF, 0, "R11 single write");

    // R5/R8: every orientation-bit combination, with noise in other bits
    for (int k = 0; k < 16; k++) begin
      logic [15:0] m;
      m = {1'b0, k[3], k[2], 1'b0, k[1], 1'b0, k[0], 9'b0};
      if (k[0] ^ k[1]) m = m | 16'h95FF;
      runSeq(2'd1, 8'h00, 16'h0000, m, 0, "R5 power-up");
      runSeq(2'd3, 8'h00, 16'h0000, 16'hFFFF, 0, "R8 resume stored");
    end

    // R6 shutdown with a start poke while busy (R9); stored word kept
    runSeq(2'd1, 8'h00, 16'h0000, 16'h2800, 0, "R5 power-up");
    runSeq(2'd2, 8'h00, 16'h0000, 16'h0000, 1, "R6 shutdown poked");
    chk(busy === 1'b0 && spiCsN === 1'b1, "R9", "idle after ignored start",
        32'({busy, spiCsN}), 32'b01);
    runSeq(2'd3, 8'h00, 16'h0000, 16'h0000, 0, "R9 resume after poke");

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule